// File: doc/BRIEF.md
# Wishbone Pipelined Link Monitor

This block watches one pipelined-mode Wishbone link between a master and a slave. It drives no bus signal. It samples cycle, strobe, write-enable, address, stall, acknowledge and error on every rising clock edge. From these it keeps a running count of requests that the slave has taken but not yet answered. When a handshake rule of the pipelined mode is broken, it reports the broken rule as a one-cycle pulse and as a sticky flag.

In pipelined mode the strobe and the acknowledge are independent. A request is taken on each edge where the strobe is high and the stall is low. Answers may come many cycles later. Holding the strobe high for an extra cycle therefore issues a further request. To expose that kind of master bug, the monitor totals the requests taken in each bus cycle and presents the total when the cycle ends. An optional single-word mode flags any total above one.

Top module: `wbp_link_monitor`

## Requirements
- R1: A request is taken on an edge that samples cycle, strobe high and stall low. The outstanding count rises by one per request taken and falls by one per acknowledge or error that answers a pending request. The new value shows on `outstanding_o` in the cycle after that edge. When a request and an answer fall on the same edge, the count does not change.
- R2: If strobe and stall are both high while cycle is high, and on the next edge cycle is high but strobe is low, flag bit 0 (stall-drop) is raised. No flag is raised if cycle falls at that edge.
- R3: The outstanding count never wraps. A request taken with the count at its maximum (2^CW-1) and no answer leaves the count at the maximum and raises flag bit 4 (overflow).
- R4: An acknowledge or error sampled while cycle is low, or while the outstanding count is zero, raises flag bit 1 (unexpected answer).
- R5: Strobe high with cycle low raises flag bit 2. Acknowledge and error high on the same edge raise flag bit 3.
- R6: While a request waits under stall, a change of address or write-enable on the next edge, with strobe still high, raises flag bit 6.
- R7: When cycle falls while a request was waiting under stall, or while the outstanding count is non-zero, `abort_o` pulses for one cycle and the outstanding count becomes zero.
- R8: On the edge that samples cycle low after it was high, `req_total_o` takes the number of requests taken during that bus cycle, saturating at 2^RW-1. `req_total_vld_o` is high for that one following cycle only.
- R9: With `single_word_i` high at the end of a bus cycle whose total exceeds one, flag bit 5 (multiple requests) is raised.
- R10: Each violation pulses its bit on `viol_pulse_o` for one cycle and sets the same bit of `viol_flags_o`. A set flag stays set until `clr_i` is sampled high. A violation on the clearing edge is still recorded.
- R11: After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr_i | input | 1 | Synchronous clear of the sticky flags |
| single_word_i | input | 1 | Flags bus cycles with more than one request |
| wb_cyc_i | input | 1 | Observed bus cycle |
| wb_stb_i | input | 1 | Observed strobe |
| wb_we_i | input | 1 | Observed write enable |
| wb_adr_i | input | AW | Observed address |
| wb_stall_i | input | 1 | Observed slave stall |
| wb_ack_i | input | 1 | Observed acknowledge |
| wb_err_i | input | 1 | Observed error |
| outstanding_o | output | CW | Requests taken but not yet answered |
| abort_o | output | 1 | One-cycle pulse on a bus abort |
| viol_pulse_o | output | 7 | Per-rule violation pulses |
| viol_flags_o | output | 7 | Sticky violation flags |
| req_total_o | output | RW | Requests taken in the last bus cycle |
| req_total_vld_o | output | 1 | `req_total_o` is valid this cycle |

## Verification
The assertions assume that the bus inputs change only between clock edges and that reset is applied before any traffic. The stall-hold and idle-strobe properties relate raw bus inputs to the pulse on the next cycle. They therefore rely on the bus being quiet during the two synchroniser cycles after reset. The stimulus drives every input on the falling edge and keeps the bus idle until reset has settled. It breaks each rule on purpose and in isolation, so that each expected flag word can be worked out by hand.

// File: rtl/wbmon_pkg.sv
package wbmon_pkg;
  localparam int unsigned NFLAG = 7;

  // bit positions of the violation vector
  localparam int FL_STALL_DROP = 0;
  localparam int FL_UNEXP_RESP = 1;
  localparam int FL_STB_IDLE   = 2;
  localparam int FL_RESP_CLASH = 3;
  localparam int FL_OVERFLOW   = 4;
  localparam int FL_MULTI_REQ  = 5;
  localparam int FL_REQ_CHANGE = 6;

  typedef logic [NFLAG-1:0] flag_vec_t;
endpackage

// File: rtl/wbmon_rules.sv
module wbmon_rules #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_i,
  input  logic          stb_i,
  input  logic          we_i,
  input  logic [AW-1:0] adr_i,
  input  logic          stall_i,
  input  logic          ack_i,
  input  logic          err_i,
  input  logic          cnt_zero_i,
  output logic          accept_o,
  output logic          resp_ok_o,
  output logic          cyc_fall_o,
  output logic          abort_o,
  output logic          abort_pulse_o,
  output logic          stall_drop_o,
  output logic          unexp_resp_o,
  output logic          stb_idle_o,
  output logic          resp_clash_o,
  output logic          req_change_o
);
  logic          prev_cyc_q, prev_wait_q, prev_we_q, abort_q;
  logic [AW-1:0] prev_adr_q;
  logic          waiting, resp, hold_en;

  // next-state / decode
  always_comb begin
    waiting      = cyc_i & stb_i & stall_i;
    resp         = ack_i | err_i;
    hold_en      = waiting;
    accept_o     = cyc_i & stb_i & ~stall_i;
    resp_ok_o    = resp & cyc_i & ~cnt_zero_i;
    cyc_fall_o   = prev_cyc_q & ~cyc_i;
    abort_o      = cyc_fall_o & (prev_wait_q | ~cnt_zero_i);
    stall_drop_o = prev_wait_q & cyc_i & ~stb_i;
    req_change_o = prev_wait_q & cyc_i & stb_i &
                   ((adr_i != prev_adr_q) | (we_i != prev_we_q));
    unexp_resp_o = resp & (~cyc_i | cnt_zero_i);
    stb_idle_o   = stb_i & ~cyc_i;
    resp_clash_o = ack_i & err_i;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_cyc_q  <= 1'b0;
      prev_wait_q <= 1'b0;
      abort_q     <= 1'b0;
    end else begin
      prev_cyc_q  <= cyc_i;
      prev_wait_q <= waiting;
      abort_q     <= abort_o;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_adr_q <= '0;
      prev_we_q  <= 1'b0;
    end else if (hold_en) begin
      prev_adr_q <= adr_i;
      prev_we_q  <= we_i;
    end
  end

  assign abort_pulse_o = abort_q;
endmodule

// File: rtl/wbmon_outstanding.sv
module wbmon_outstanding #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept_i,
  input  logic          resp_ok_i,
  input  logic          abort_i,
  output logic [CW-1:0] cnt_o,
  output logic          cnt_zero_o,
  output logic          ovf_o
);
  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    ovf_o = accept_i & ~resp_ok_i & (cnt_q == CMAX);
    cnt_d = cnt_q;
    if (abort_i)
      cnt_d = '0;
    else if (accept_i & ~resp_ok_i & ~ovf_o)
      cnt_d = cnt_q + CW'(1);
    else if (~accept_i & resp_ok_i)
      cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o      = cnt_q;
  assign cnt_zero_o = (cnt_q == '0);
endmodule

// File: rtl/wbmon_cycle_tally.sv
module wbmon_cycle_tally #(
  parameter int unsigned RW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept_i,
  input  logic          cyc_fall_i,
  input  logic          single_word_i,
  output logic [RW-1:0] total_o,
  output logic          total_vld_o,
  output logic          multi_o
);
  localparam logic [RW-1:0] RMAX = '1;

  logic [RW-1:0] run_q, run_d, tot_q;
  logic          vld_q, tot_en;

  always_comb begin
    run_d  = run_q;
    tot_en = cyc_fall_i;
    if (cyc_fall_i)
      run_d = '0;
    else if (accept_i && (run_q != RMAX))
      run_d = run_q + RW'(1);
    multi_o = cyc_fall_i & single_word_i & (run_q > RW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      vld_q <= 1'b0;
    end else begin
      run_q <= run_d;
      vld_q <= cyc_fall_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tot_q <= '0;
    else if (tot_en) tot_q <= run_q;
  end

  assign total_o     = tot_q;
  assign total_vld_o = vld_q;
endmodule

// File: rtl/wbmon_flags.sv
module wbmon_flags #(
  parameter int unsigned N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic [N-1:0] viol_i,
  output logic [N-1:0] pulse_o,
  output logic [N-1:0] flags_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic f_q, f_d, p_q;

    always_comb f_d = (clr_i ? 1'b0 : f_q) | viol_i[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        f_q <= 1'b0;
        p_q <= 1'b0;
      end else begin
        f_q <= f_d;
        p_q <= viol_i[g];
      end
    end

    assign flags_o[g] = f_q;
    assign pulse_o[g] = p_q;
  end
endmodule

// File: rtl/wbp_link_monitor.sv
module wbp_link_monitor
  import wbmon_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 4,
  parameter int unsigned RW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             single_word_i,
  input  logic             wb_cyc_i,
  input  logic             wb_stb_i,
  input  logic             wb_we_i,
  input  logic [AW-1:0]    wb_adr_i,
  input  logic             wb_stall_i,
  input  logic             wb_ack_i,
  input  logic             wb_err_i,
  output logic [CW-1:0]    outstanding_o,
  output logic             abort_o,
  output logic [NFLAG-1:0] viol_pulse_o,
  output logic [NFLAG-1:0] viol_flags_o,
  output logic [RW-1:0]    req_total_o,
  output logic             req_total_vld_o
);
  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic      accept, resp_ok, cyc_fall, abort, cnt_zero, ovf, multi;
  logic      stall_drop, unexp_resp, stb_idle, resp_clash, req_change;
  flag_vec_t viol;

  wbmon_rules #(.AW(AW)) i_rules (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .cyc_i        (wb_cyc_i),
    .stb_i        (wb_stb_i),
    .we_i         (wb_we_i),
    .adr_i        (wb_adr_i),
    .stall_i      (wb_stall_i),
    .ack_i        (wb_ack_i),
    .err_i        (wb_err_i),
    .cnt_zero_i   (cnt_zero),
    .accept_o     (accept),
    .resp_ok_o    (resp_ok),
    .cyc_fall_o   (cyc_fall),
    .abort_o      (abort),
    .abort_pulse_o(abort_o),
    .stall_drop_o (stall_drop),
    .unexp_resp_o (unexp_resp),
    .stb_idle_o   (stb_idle),
    .resp_clash_o (resp_clash),
    .req_change_o (req_change)
  );

  wbmon_outstanding #(.CW(CW)) i_outstanding (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .accept_i  (accept),
    .resp_ok_i (resp_ok),
    .abort_i   (abort),
    .cnt_o     (outstanding_o),
    .cnt_zero_o(cnt_zero),
    .ovf_o     (ovf)
  );

  wbmon_cycle_tally #(.RW(RW)) i_tally (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .accept_i     (accept),
    .cyc_fall_i   (cyc_fall),
    .single_word_i(single_word_i),
    .total_o      (req_total_o),
    .total_vld_o  (req_total_vld_o),
    .multi_o      (multi)
  );

  always_comb begin
    viol                = '0;
    viol[FL_STALL_DROP] = stall_drop;
    viol[FL_UNEXP_RESP] = unexp_resp;
    viol[FL_STB_IDLE]   = stb_idle;
    viol[FL_RESP_CLASH] = resp_clash;
    viol[FL_OVERFLOW]   = ovf;
    viol[FL_MULTI_REQ]  = multi;
    viol[FL_REQ_CHANGE] = req_change;
  end

  wbmon_flags #(.N(NFLAG)) i_flags (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .clr_i  (clr_i),
    .viol_i (viol),
    .pulse_o(viol_pulse_o),
    .flags_o(viol_flags_o)
  );
endmodule

// File: rtl/wbp_link_monitor_chk.sv
module wbp_link_monitor_chk
  import wbmon_pkg::*;
#(
  parameter int unsigned CW = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr_i,
  input logic             wb_cyc_i,
  input logic             wb_stb_i,
  input logic             wb_stall_i,
  input logic [CW-1:0]    outstanding_o,
  input logic             abort_o,
  input logic [NFLAG-1:0] viol_pulse_o,
  input logic [NFLAG-1:0] viol_flags_o,
  input logic             req_total_vld_o
);
  localparam logic [CW-1:0] CMAX = '1;

  // R1: the count moves by at most one per edge unless an abort empties it
  p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (abort_o || (outstanding_o == $past(outstanding_o)) ||
              (outstanding_o == $past(outstanding_o) + CW'(1)) ||
              (outstanding_o + CW'(1) == $past(outstanding_o))));

  // R2: a stalled request withdrawn while the cycle continues is reported
  p_stall_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_cyc_i && wb_stb_i && wb_stall_i) ##1 (wb_cyc_i && !wb_stb_i)
    |=> viol_pulse_o[FL_STALL_DROP]);

  // R3: an overflow leaves the count at its ceiling
  p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    viol_pulse_o[FL_OVERFLOW] |-> (outstanding_o == CMAX));

  // R5: strobe outside a cycle is reported
  p_stb_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_stb_i && !wb_cyc_i) |=> viol_pulse_o[FL_STB_IDLE]);

  // R7: an abort leaves nothing outstanding
  p_abort_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> (outstanding_o == '0));

  // R8: the total is valid for a single cycle
  p_total_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_total_vld_o |=> !req_total_vld_o);

  // R10: flags hold without a clear, and every pulse is mirrored in the flags
  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((viol_flags_o & $past(viol_flags_o)) == $past(viol_flags_o)));

  p_pulse_sets_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((viol_flags_o & viol_pulse_o) == viol_pulse_o));
endmodule

bind wbp_link_monitor wbp_link_monitor_chk #(.CW(CW)) i_chk (
  .clk            (clk),
  .rst_n          (rst_sync_n),
  .clr_i          (clr_i),
  .wb_cyc_i       (wb_cyc_i),
  .wb_stb_i       (wb_stb_i),
  .wb_stall_i     (wb_stall_i),
  .outstanding_o  (outstanding_o),
  .abort_o        (abort_o),
  .viol_pulse_o   (viol_pulse_o),
  .viol_flags_o   (viol_flags_o),
  .req_total_vld_o(req_total_vld_o)
);

// File: tb/test_wbp_link_monitor.sv
module test_wbp_link_monitor;
  localparam int AW = 8;
  localparam int CW = 2;
  localparam int RW = 3;

  logic          clk = 1'b0;
  logic          rst_n, clr, single_word;
  logic          cyc, stb, we, stall, ack, err;
  logic [AW-1:0] adr;
  logic [CW-1:0] outstanding;
  logic          abort;
  logic [6:0]    pulse, flags;
  logic [RW-1:0] total;
  logic          total_vld;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  wbp_link_monitor #(.AW(AW), .CW(CW), .RW(RW)) i_wbp_link_monitor (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .single_word_i(single_word),
    .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we), .wb_adr_i(adr),
    .wb_stall_i(stall), .wb_ack_i(ack), .wb_err_i(err),
    .outstanding_o(outstanding), .abort_o(abort), .viol_pulse_o(pulse),
    .viol_flags_o(flags), .req_total_o(total), .req_total_vld_o(total_vld)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input logic c, input logic s, input logic st,
                       input logic a, input logic e);
    cyc = c; stb = s; stall = st; ack = a; err = e;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clear_flags();
    drive(0, 0, 0, 0, 0);
    clr = 1'b1;
    step();
    clr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hang expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; clr = 1'b0; single_word = 1'b0; we = 1'b0; adr = '0;
    drive(0, 0, 0, 0, 0);
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();

    // R11: reset state
    chk("R11 outstanding", int'(outstanding), 0);
    chk("R11 flags", int'(flags), 0);
    chk("R11 pulses", int'(pulse), 0);
    chk("R11 abort", int'(abort), 0);
    chk("R11 total valid", int'(total_vld), 0);

    // R1/R8/R9: n requests, then n lagging answers, both modes
    for (int mode = 0; mode < 2; mode++) begin
      for (int n = 1; n <= 3; n++) begin
        single_word = mode[0];
        for (int i = 1; i <= n; i++) begin
          drive(1, 1, 0, 0, 0); step();
          chk("R1 count rises", int'(outstanding), i);
        end
        for (int i = n - 1; i >= 0; i--) begin
          drive(1, 0, 0, 1, 0); step();
          chk("R1 count falls", int'(outstanding), i);
        end
        drive(0, 0, 0, 0, 0); step();
        chk("R8 total", int'(total), n);
        chk("R8 valid", int'(total_vld), 1);
        chk("R7 no abort on clean end", int'(abort), 0);
        chk("R9 multi-request flag", int'(flags), (mode == 1 && n > 1) ? 32 : 0);
        step();
        chk("R8 valid one cycle", int'(total_vld), 0);
        clear_flags();
      end
    end
    single_word = 1'b0;

    // R1: request and answer on the same edge keep the count level
    for (int n = 2; n <= 5; n++) begin
      drive(1, 1, 0, 0, 0); step();
      for (int i = 2; i <= n; i++) begin
        drive(1, 1, 0, 1, 0); step();
        chk("R1 overlap level", int'(outstanding), 1);
      end
      drive(1, 0, 0, 1, 0); step();
      chk("R1 overlap drained", int'(outstanding), 0);
      drive(0, 0, 0, 0, 0); step();
      chk("R8 overlap total", int'(total), n);
      chk("R10 no flags on legal traffic", int'(flags), 0);
    end

    // R1: stalled strobes are not taken
    drive(1, 1, 1, 0, 0); step(); step();
    chk("R1 stall not taken", int'(outstanding), 0);
    drive(1, 1, 0, 0, 0); step();
    chk("R1 taken after stall", int'(outstanding), 1);
    drive(1, 0, 0, 1, 0); step();
    drive(0, 0, 0, 0, 0); step();
    chk("R8 stalled total", int'(total), 1);
    chk("R2 held strobe legal", int'(flags), 0);

    // R2: strobe dropped under stall; R10 stickiness and clear
    drive(1, 1, 1, 0, 0); step();
    drive(1, 0, 0, 0, 0); step();
    chk("R2 stall-drop pulse", int'(pulse), 1);
    chk("R2 stall-drop flag", int'(flags), 1);
    step();
    chk("R10 pulse one cycle", int'(pulse), 0);
    chk("R10 flag sticky", int'(flags), 1);
    drive(0, 0, 0, 0, 0); step();
    chk("R7 no abort when idle", int'(abort), 0);
    clear_flags();
    chk("R10 clear", int'(flags), 0);

    // R7: cycle dropped under stall is an abort, not a stall-drop
    drive(1, 1, 1, 0, 0); step();
    drive(0, 0, 0, 0, 0); step();
    chk("R7 abort on stalled drop", int'(abort), 1);
    chk("R2 no flag when cycle falls", int'(flags), 0);
    step();
    chk("R7 abort one cycle", int'(abort), 0);

    // R3: overflow holds the count; R7 abort with answers pending
    for (int i = 1; i <= 4; i++) begin
      drive(1, 1, 0, 0, 0); step();
      chk("R3 count saturates", int'(outstanding), (i > 3) ? 3 : i);
    end
    chk("R3 overflow flag", int'(flags), 16);
    drive(0, 0, 0, 0, 0); step();
    chk("R7 abort with pending", int'(abort), 1);
    chk("R7 count emptied", int'(outstanding), 0);
    chk("R8 total past overflow", int'(total), 4);
    clear_flags();

    // R4: answers with nothing pending or outside a cycle
    drive(1, 0, 0, 1, 0); step();
    chk("R4 answer with none pending", int'(pulse), 2);
    drive(0, 0, 0, 0, 0); step();
    clear_flags();
    drive(0, 0, 0, 0, 1); step();
    chk("R4 error outside cycle", int'(pulse), 2);
    clear_flags();

    // R5: strobe outside a cycle; both answers at once
    drive(0, 1, 0, 0, 0); step();
    chk("R5 idle strobe", int'(pulse), 4);
    clear_flags();
    drive(1, 0, 0, 1, 1); step();
    chk("R5 answer clash", int'(flags), 2 + 8);
    drive(0, 0, 0, 0, 0); step();
    clear_flags();

    // R6: request altered while stalled
    adr = 8'd5; drive(1, 1, 1, 0, 0); step();
    adr = 8'd6; step();
    chk("R6 address change", int'(pulse), 64);
    we = 1'b1; step();
    chk("R6 write-enable change", int'(pulse), 64);
    drive(1, 1, 0, 0, 0); step();
    drive(1, 0, 0, 1, 0); step();
    drive(0, 0, 0, 0, 0); step();
    chk("R6 flag only", int'(flags), 64);
    we = 1'b0;

    // R10: a violation on the clearing edge survives the clear
    clr = 1'b1; drive(0, 1, 0, 0, 0); step();
    clr = 1'b0; drive(0, 0, 0, 0, 0);
    chk("R10 set beats clear", int'(flags), 4);
    clear_flags();
    chk("R10 cleared", int'(flags), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule